// File: doc/BRIEF.md
# Banked Interrupt Status and Enable Controller

This block collects interrupt requests from peripherals into several banks of 32 sources each. Every source input that is high latches a pending bit in its bank's status register. A per-bank enable register decides which pending bits may reach the processor. The masked view, status AND enable, drives one request line per bank. It also drives an encoded index of the highest-numbered pending enabled source, so the service routine can pick the source to handle without scanning the register.

Software reaches the registers through a plain 32-bit read/write port with byte addressing. Bank n starts at byte address n*0x28, and each bank holds five word registers. A service routine reads the masked view or the encoded index, clears the pending bit by writing a 1 to it, and repeats until the bank's request line drops. The register port is a control path, not a stream: a write takes effect on the edge where it is presented, and a read returns its word one cycle later with a valid strobe. There is no back-pressure.

Top module: `irq_bank_ctrl`

## Requirements
- R1: Bank n occupies byte addresses n*0x28 to n*0x28+0x27, with these offsets:
  - 0x00: pending status.
  - 0x08: enable.
  - 0x10: masked view.
  - 0x18: routing word.
  - 0x20: mask-control word.

  Any other offset, or any address beyond the last bank, reads as 0, and writes to it change nothing.
- R2: A source input that is high at a clock edge sets its pending bit at that edge. The bit stays set after the input drops. Bit i of bank n is source input n*32+i.
- R3: Writing 1 to a bit of the status register clears that pending bit. Writing 0 to a bit leaves it unchanged.
- R4: When a source is high in the same cycle as a write-1-to-clear of its bit, the bit stays set.
- R5: A cleared enable bit blocks its source from the masked view, the request line and the index. The pending bit is kept and appears once the source is enabled again.
- R6: The masked view reads as status AND enable, and writes to it have no effect.
- R7: irq_o[n] is high exactly when bank n's masked view is nonzero.
- R8: top_idx_o[n*5 +: 5] holds the index of the highest set bit of bank n's masked view. top_vld_o[n] is high when that view is nonzero.
- R9: After reset, all five registers of every bank read 0 and all request lines are low.
- R10: The start-up sequence is accepted in every bank and leaves no request pending. That sequence writes enable to 0, status and mask-control to all ones, and routing to 0. The routing and mask-control words read back what was written.
- R11: A read presented at a clock edge returns its word on cfg_rdata with cfg_rvalid high for the following cycle. The word is the value the register held before any write at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NBANK*NSRC | Peripheral request inputs, bank-major |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | AW | Byte address |
| cfg_wdata | input | NSRC | Write data |
| cfg_rdata | output | NSRC | Read data, one cycle after cfg_rd |
| cfg_rvalid | output | 1 | Read data valid |
| irq_o | output | NBANK | Per-bank processor request line |
| top_idx_o | output | NBANK*IW | Highest pending enabled source per bank |
| top_vld_o | output | NBANK | Index valid per bank |

## Verification
The bench builds the block with its default parameters: five banks of 32 sources and an 8-bit address. This puts the last bank's window, 0xA0 to 0xC7, and an address past it within reach of directed accesses. With 32 sources the encoder's top position, bit 31, can compete with a low bit for priority. Bit collisions between a source and a write-1-to-clear are driven in the exact same cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [2:0] {
    RK_STAT  = 3'd0,
    RK_EN    = 3'd1,
    RK_OUT   = 3'd2,
    RK_ROUTE = 3'd3,
    RK_MCTL  = 3'd4,
    RK_NONE  = 3'd7
  } reg_kind_e;

  localparam int OFF_STAT  = 'h00;
  localparam int OFF_EN    = 'h08;
  localparam int OFF_OUT   = 'h10;
  localparam int OFF_ROUTE = 'h18;
  localparam int OFF_MCTL  = 'h20;

  function automatic reg_kind_e kind_of(input int off);
    case (off)
      OFF_STAT:  return RK_STAT;
      OFF_EN:    return RK_EN;
      OFF_OUT:   return RK_OUT;
      OFF_ROUTE: return RK_ROUTE;
      OFF_MCTL:  return RK_MCTL;
      default:   return RK_NONE;
    endcase
  endfunction
endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec #(
  parameter int NBANK  = 5,
  parameter int AW     = 8,
  parameter int STRIDE = 40,
  parameter int BW     = 3
) (
  input  logic [AW-1:0]         addr,
  output logic [NBANK-1:0]      hit,
  output logic [BW-1:0]         bank,
  output irq_pkg::reg_kind_e    kind
);
  always_comb begin
    hit  = '0;
    bank = '0;
    kind = irq_pkg::RK_NONE;
    for (int b = 0; b < NBANK; b++) begin
      if ((int'(addr) >= b*STRIDE) && (int'(addr) < (b+1)*STRIDE)) begin
        hit[b] = 1'b1;
        bank   = BW'(b);
        kind   = irq_pkg::kind_of(int'(addr) - b*STRIDE);
      end
    end
  end
endmodule

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src,
  input  logic            wr_stat,
  input  logic            wr_en,
  input  logic            wr_route,
  input  logic            wr_mctl,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] stat_q,
  output logic [NSRC-1:0] en_q,
  output logic [NSRC-1:0] route_q,
  output logic [NSRC-1:0] mctl_q,
  output logic [NSRC-1:0] out_stat,
  output logic            irq
);
  logic [NSRC-1:0] clr_mask;
  logic [NSRC-1:0] stat_d;

  assign clr_mask = wr_stat ? wdata : '0;
  assign stat_d   = (stat_q & ~clr_mask) | src;
  assign out_stat = stat_q & en_q;
  assign irq      = |out_stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      en_q    <= '0;
      route_q <= '0;
      mctl_q  <= '0;
    end else begin
      stat_q <= stat_d;
      if (wr_en)    en_q    <= wdata;
      if (wr_route) route_q <= wdata;
      if (wr_mctl)  mctl_q  <= wdata;
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NSRC = 32,
  parameter int IW   = 5
) (
  input  logic [NSRC-1:0] vec,
  output logic [IW-1:0]   idx,
  output logic            vld
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (vec[i]) idx = IW'(i);
    end
  end
  assign vld = |vec;
endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl #(
  parameter int NBANK  = 5,
  parameter int NSRC   = 32,
  parameter int AW     = 8,
  parameter int STRIDE = 40,
  parameter int IW     = $clog2(NSRC)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NBANK*NSRC-1:0] src_i,
  input  logic                  cfg_wr,
  input  logic                  cfg_rd,
  input  logic [AW-1:0]         cfg_addr,
  input  logic [NSRC-1:0]       cfg_wdata,
  output logic [NSRC-1:0]       cfg_rdata,
  output logic                  cfg_rvalid,
  output logic [NBANK-1:0]      irq_o,
  output logic [NBANK*IW-1:0]   top_idx_o,
  output logic [NBANK-1:0]      top_vld_o
);
  localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1;

  logic [NBANK-1:0]   hit;
  logic [BW-1:0]      sel_bank;
  irq_pkg::reg_kind_e sel_kind;

  logic [NSRC-1:0] stat_a  [NBANK];
  logic [NSRC-1:0] en_a    [NBANK];
  logic [NSRC-1:0] route_a [NBANK];
  logic [NSRC-1:0] mctl_a  [NBANK];
  logic [NSRC-1:0] out_a   [NBANK];

  logic [NBANK*NSRC-1:0] stat_flat;
  logic [NBANK*NSRC-1:0] out_flat;

  irq_addr_dec #(.NBANK(NBANK), .AW(AW), .STRIDE(STRIDE), .BW(BW)) u_dec (
    .addr (cfg_addr),
    .hit  (hit),
    .bank (sel_bank),
    .kind (sel_kind)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic wsel;
    assign wsel = cfg_wr & hit[b];

    irq_bank #(.NSRC(NSRC)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .src      (src_i[b*NSRC +: NSRC]),
      .wr_stat  (wsel && (sel_kind == irq_pkg::RK_STAT)),
      .wr_en    (wsel && (sel_kind == irq_pkg::RK_EN)),
      .wr_route (wsel && (sel_kind == irq_pkg::RK_ROUTE)),
      .wr_mctl  (wsel && (sel_kind == irq_pkg::RK_MCTL)),
      .wdata    (cfg_wdata),
      .stat_q   (stat_a[b]),
      .en_q     (en_a[b]),
      .route_q  (route_a[b]),
      .mctl_q   (mctl_a[b]),
      .out_stat (out_a[b]),
      .irq      (irq_o[b])
    );

    irq_prio_enc #(.NSRC(NSRC), .IW(IW)) u_enc (
      .vec (out_a[b]),
      .idx (top_idx_o[b*IW +: IW]),
      .vld (top_vld_o[b])
    );

    assign stat_flat[b*NSRC +: NSRC] = stat_a[b];
    assign out_flat[b*NSRC +: NSRC]  = out_a[b];
  end

  logic [NSRC-1:0] rd_word;
  always_comb begin
    rd_word = '0;
    if (|hit) begin
      case (sel_kind)
        irq_pkg::RK_STAT:  rd_word = stat_a[sel_bank];
        irq_pkg::RK_EN:    rd_word = en_a[sel_bank];
        irq_pkg::RK_OUT:   rd_word = out_a[sel_bank];
        irq_pkg::RK_ROUTE: rd_word = route_a[sel_bank];
        irq_pkg::RK_MCTL:  rd_word = mctl_a[sel_bank];
        default:           rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_rdata  <= '0;
      cfg_rvalid <= 1'b0;
    end else begin
      cfg_rvalid <= cfg_rd;
      if (cfg_rd) cfg_rdata <= rd_word;
    end
  end
endmodule

// File: rtl/irq_bank_ctrl_chk.sv
module irq_bank_ctrl_chk #(
  parameter int NBANK = 5,
  parameter int NSRC  = 32,
  parameter int IW    = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NBANK*NSRC-1:0] src_i,
  input logic                  cfg_rd,
  input logic                  cfg_rvalid,
  input logic [NBANK-1:0]      hit,
  input logic [NBANK*NSRC-1:0] stat_flat,
  input logic [NBANK*NSRC-1:0] out_flat,
  input logic [NBANK-1:0]      irq_o,
  input logic [NBANK*IW-1:0]   top_idx_o,
  input logic [NBANK-1:0]      top_vld_o
);
  assert_one_bank_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));

  assert_src_latches_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i != '0) |=> ((stat_flat & $past(src_i)) == $past(src_i)));

  assert_no_spurious_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((stat_flat & ~$past(stat_flat) & ~$past(src_i)) == '0));

  assert_line_matches_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == top_vld_o);

  assert_read_returns_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd |=> cfg_rvalid);

  for (genvar b = 0; b < NBANK; b++) begin : g_chk
    assert_index_bit_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      top_vld_o[b] |-> out_flat[b*NSRC + int'(top_idx_o[b*IW +: IW])]);
    assert_index_is_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
      top_vld_o[b] |-> ((out_flat[b*NSRC +: NSRC] >> top_idx_o[b*IW +: IW]) == 1));
  end
endmodule

bind irq_bank_ctrl irq_bank_ctrl_chk #(.NBANK(NBANK), .NSRC(NSRC), .IW(IW)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .src_i      (src_i),
  .cfg_rd     (cfg_rd),
  .cfg_rvalid (cfg_rvalid),
  .hit        (hit),
  .stat_flat  (stat_flat),
  .out_flat   (out_flat),
  .irq_o      (irq_o),
  .top_idx_o  (top_idx_o),
  .top_vld_o  (top_vld_o)
);

// File: tb/test_irq_bank_ctrl.sv
`timescale 1ns/1ps
module test_irq_bank_ctrl;
  localparam int NBANK = 5;
  localparam int NSRC  = 32;
  localparam int AW    = 8;
  localparam int IW    = 5;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic [NBANK*NSRC-1:0] src_i = '0;
  logic                  cfg_wr = 1'b0;
  logic                  cfg_rd = 1'b0;
  logic [AW-1:0]         cfg_addr = '0;
  logic [NSRC-1:0]       cfg_wdata = '0;
  logic [NSRC-1:0]       cfg_rdata;
  logic                  cfg_rvalid;
  logic [NBANK-1:0]      irq_o;
  logic [NBANK*IW-1:0]   top_idx_o;
  logic [NBANK-1:0]      top_vld_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_bank_ctrl #(.NBANK(NBANK), .NSRC(NSRC), .AW(AW)) i_irq_bank_ctrl (.*);

  function automatic logic [AW-1:0] ad(input int bank, input int off);
    return AW'(bank*40 + off);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_rd = 1'b0;
    chk("R11 rvalid", 32'(cfg_rvalid), 32'd1);
    d = cfg_rdata;
  endtask

  task automatic pulse_src(input int bank, input int bit_i);
    @(negedge clk);
    src_i[bank*NSRC + bit_i] = 1'b1;
    @(negedge clk);
    src_i[bank*NSRC + bit_i] = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R9 irq", 32'(irq_o), 32'd0);
    chk("R9 vld", 32'(top_vld_o), 32'd0);
    for (int o = 0; o < 5; o++) begin
      reg_rd(ad(3, o*8), d);
      chk("R9 reg", d, 32'd0);
    end
  endtask

  task automatic t_init();
    logic [31:0] d;
    for (int b = 0; b < NBANK; b++) begin
      reg_wr(ad(b, 'h08), 32'h0);
      reg_wr(ad(b, 'h00), 32'hFFFF_FFFF);
      reg_wr(ad(b, 'h20), 32'hFFFF_FFFF);
      reg_wr(ad(b, 'h18), 32'h0);
    end
    reg_rd(ad(4, 'h20), d);
    chk("R10 R1 mctl bank4", d, 32'hFFFF_FFFF);
    reg_rd(ad(4, 'h18), d);
    chk("R10 route bank4", d, 32'h0);
    reg_rd(ad(4, 'h00), d);
    chk("R10 status bank4", d, 32'h0);
    chk("R10 irq", 32'(irq_o), 32'd0);
    reg_wr(ad(2, 'h18), 32'h1234_5678);
    reg_rd(ad(2, 'h18), d);
    chk("R10 route readback", d, 32'h1234_5678);
  endtask

  task automatic t_latch_enable();
    logic [31:0] d;
    pulse_src(1, 5);
    reg_rd(ad(1, 'h00), d);
    chk("R2 latched", d, 32'h20);
    chk("R5 irq blocked", 32'(irq_o[1]), 32'd0);
    reg_rd(ad(1, 'h10), d);
    chk("R5 view blocked", d, 32'h0);
    reg_wr(ad(1, 'h08), 32'h20);
    chk("R7 irq bank1", 32'(irq_o), 32'b00010);
    chk("R8 idx bank1", 32'(top_idx_o[1*IW +: IW]), 32'd5);
    reg_rd(ad(1, 'h10), d);
    chk("R6 view", d, 32'h20);
    reg_wr(ad(1, 'h08), 32'h0);
    chk("R5 irq off", 32'(irq_o[1]), 32'd0);
    reg_rd(ad(1, 'h00), d);
    chk("R5 kept pending", d, 32'h20);
  endtask

  task automatic t_readonly_unmapped();
    logic [31:0] d;
    reg_wr(ad(1, 'h10), 32'hFFFF_FFFF);
    reg_rd(ad(1, 'h00), d);
    chk("R6 status untouched", d, 32'h20);
    reg_rd(ad(1, 'h08), d);
    chk("R6 enable untouched", d, 32'h0);
    reg_wr(ad(1, 'h04), 32'hFFFF_FFFF);
    reg_rd(ad(1, 'h04), d);
    chk("R1 hole reads 0", d, 32'h0);
    reg_rd(ad(1, 'h08), d);
    chk("R1 hole write ignored", d, 32'h0);
    reg_wr(8'hD0, 32'hFFFF_FFFF);
    reg_rd(8'hD0, d);
    chk("R1 beyond banks", d, 32'h0);
    reg_wr(ad(1, 'h00), 32'h20);
    reg_rd(ad(1, 'h00), d);
    chk("R3 clear bank1", d, 32'h0);
  endtask

  task automatic t_prio();
    logic [31:0] d;
    reg_wr(ad(4, 'h08), 32'hFFFF_FFFF);
    pulse_src(4, 3);
    chk("R8 idx low", 32'(top_idx_o[4*IW +: IW]), 32'd3);
    pulse_src(4, 31);
    chk("R8 idx top", 32'(top_idx_o[4*IW +: IW]), 32'd31);
    chk("R8 vld", 32'(top_vld_o), 32'b10000);
    reg_wr(ad(4, 'h00), 32'h0);
    reg_rd(ad(4, 'h00), d);
    chk("R3 zero write", d, 32'h8000_0008);
    reg_wr(ad(4, 'h00), 32'h8000_0000);
    chk("R3 R8 idx after clear", 32'(top_idx_o[4*IW +: IW]), 32'd3);
    reg_wr(ad(4, 'h00), 32'h8);
    chk("R7 irq dropped", 32'(irq_o), 32'd0);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    @(negedge clk);
    src_i[2*NSRC + 7] = 1'b1;
    cfg_wr = 1'b1; cfg_addr = ad(2, 'h00); cfg_wdata = 32'h80;
    @(negedge clk);
    cfg_wr = 1'b0;
    src_i[2*NSRC + 7] = 1'b0;
    reg_rd(ad(2, 'h00), d);
    chk("R4 set wins", d, 32'h80);
    reg_wr(ad(2, 'h00), 32'h80);
    reg_rd(ad(2, 'h00), d);
    chk("R4 later clear", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_init();
    t_latch_enable();
    t_readonly_unmapped();
    t_prio();
    t_set_wins();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule